// File: doc/BRIEF.md
# Video raster and capture/display mode sequencer

This block generates the line and frame timing for a noninterlaced grayscale raster. The visible image is 256 lines of 256 pixels. A horizontal counter steps through the visible pixels and then a blanking region made of front porch, sync pulse and back porch. A vertical counter steps through lines in the same way. From these counters the block produces a composite sync, a blank flag, a pixel shift enable for the frame-store shift path and an enable for the capture converter. The sync output drives both the display converter and the camera, so the camera needs no genlock input.

The block runs in one of two modes. In **digitize** mode, camera pixels are captured and then written into the frame store. In **freeze** mode, stored rows are read out to the display and the capture converter is switched off. A host bit requests the mode. That bit crosses two flip-flops and is loaded into the effective mode on the first pixel of the first vertical blanking line, so the mode never changes in the middle of a frame.

Once per qualifying line, during horizontal blanking, the block raises a memory-transfer request and presents the row index that the transfer concerns. The request is a small state machine with three states. **IDLE** moves to **WAIT** when horizontal blanking begins on a qualifying line. **WAIT** holds the request and moves to **HOLD** when the acknowledge is sampled. **HOLD** moves back to **IDLE** when the next visible region starts. In freeze mode, a line qualifies when the following line is visible, and the row index is that following row. In digitize mode, a line qualifies when it is itself visible, and the row index is that same row.

Top module: `vid_seq_top`

## Requirements
- R1: With reset released at pixel 0 of line 0, `pix_shift_o` is 1 exactly when the pixel count is below H_ACT and the line count is below V_ACT, and `blank_o` is its complement. The pixel count wraps at H_ACT+H_FP+H_SYNC+H_BP and advances the line count, which wraps at V_ACT+V_FP+V_SYNC+V_BP.
- R2: `sync_o` is the exclusive OR of a horizontal pulse (pixel count in [H_ACT+H_FP, H_ACT+H_FP+H_SYNC)) and a vertical pulse (line count in [V_ACT+V_FP, V_ACT+V_FP+V_SYNC)). It is therefore never 1 while `pix_shift_o` is 1.
- R3: The effective mode resets to freeze. It changes only on the edge where the pixel count is 0 and the line count is V_ACT, and it then takes the synchronized `mode_req_i` (1 = digitize). Pulses of `mode_req_i` that are over before that edge have no effect.
- R4: `adc_en_o` is 1 in digitize mode and 0 in freeze mode.
- R5: In freeze mode, `xfer_req_o` rises one cycle after the pixel count reaches H_ACT, but only on line V_TOT-1 or on a line below V_ACT-1. While it is high, `row_o` shows the next line's row (0 after line V_TOT-1).
- R6: In digitize mode, `xfer_req_o` rises one cycle after the pixel count reaches H_ACT on every line below V_ACT. While it is high, `row_o` shows that line's row.
- R7: `xfer_req_o` stays high until `xfer_ack_i` is sampled high and drops on the following cycle. No second request is raised on the same line.
- R8: `row_o` is stable for as long as `xfer_req_o` stays high.
- R9: Counting from one vertical blanking start to the next, exactly V_ACT requests are raised, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req_i | input | 1 | Host mode request, 1 = digitize, 0 = freeze; asynchronous |
| xfer_ack_i | input | 1 | Transfer completion from the frame-store controller |
| sync_o | output | 1 | Composite sync, active high |
| blank_o | output | 1 | Blanking, high outside the visible area |
| pix_shift_o | output | 1 | Shift enable for the frame-store pixel path |
| adc_en_o | output | 1 | Capture converter enable |
| xfer_req_o | output | 1 | Row transfer request |
| row_o | output | $clog2(V_ACT) | Row addressed by the pending transfer |

## Verification
The assertions assume that `xfer_ack_i` is raised only while a request is pending. They also assume it arrives before the horizontal blank ends, so that no request is still open when the next visible region begins. The stimulus meets both assumptions. The bench acknowledges after a delay of one to six cycles, which it changes every frame and which always fits in the eight-cycle blank of the small configuration. It clears the acknowledge as soon as the request drops. Mode requests are changed in the middle of a frame, well away from the vertical load point, so the two synchronizer stages always settle before that point.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;

    typedef enum logic {
        MODE_FREEZE   = 1'b0,
        MODE_DIGITIZE = 1'b1
    } vmode_e;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_WAIT = 2'd1,
        XF_HOLD = 2'd2
    } xfer_st_e;

endpackage

// File: rtl/raster_cnt.sv
module raster_cnt #(
    parameter int TOTAL = 8,
    parameter int W     = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] LAST = W'(TOTAL - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/span_decode.sv
module span_decode #(
    parameter int ACT  = 4,
    parameter int FP   = 1,
    parameter int SYNC = 1,
    parameter int W    = 4
) (
    input  logic [W-1:0] cnt_i,
    output logic         act_o,
    output logic         sync_o
);
    localparam logic [W-1:0] SYNC_LO = W'(ACT + FP);
    localparam logic [W-1:0] SYNC_HI = W'(ACT + FP + SYNC);

    always_comb begin
        act_o  = cnt_i < W'(ACT);
        sync_o = (cnt_i >= SYNC_LO) && (cnt_i < SYNC_HI);
    end
endmodule

// File: rtl/mode_retime.sv
module mode_retime
    import vid_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_i,
    input  logic   load_i,
    output vmode_e mode_o
);
    logic   meta_q;
    logic   safe_q;
    vmode_e mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            safe_q <= 1'b0;
            mode_q <= MODE_FREEZE;
        end else begin
            meta_q <= req_i;
            safe_q <= meta_q;
            if (load_i) mode_q <= vmode_e'(safe_q);
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import vid_seq_pkg::*;
#(
    parameter int V_ACT = 256,
    parameter int V_TOT = 262,
    parameter int VW    = 9,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             hblank_i,
    input  logic [VW-1:0]    vc_i,
    input  vmode_e           mode_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [ROW_W-1:0] row_o
);
    xfer_st_e         state_q;
    xfer_st_e         state_d;
    logic             line_ok;
    logic [ROW_W-1:0] tgt_row;
    logic [ROW_W-1:0] row_q;

    // Line qualification and target row for the active mode
    always_comb begin
        line_ok = 1'b0;
        tgt_row = '0;
        unique case (mode_i)
            MODE_DIGITIZE: begin
                line_ok = vc_i < VW'(V_ACT);
                tgt_row = ROW_W'(vc_i);
            end
            MODE_FREEZE: begin
                if (vc_i == VW'(V_TOT - 1)) begin
                    line_ok = 1'b1;
                    tgt_row = '0;
                end else begin
                    line_ok = vc_i < VW'(V_ACT - 1);
                    tgt_row = ROW_W'(vc_i + VW'(1));
                end
            end
            default: begin
                line_ok = 1'b0;
                tgt_row = '0;
            end
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (launch_i && line_ok) state_d = XF_WAIT;
            XF_WAIT: if (ack_i)               state_d = XF_HOLD;
            XF_HOLD: if (!hblank_i)           state_d = XF_IDLE;
            default:                          state_d = XF_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    // Row captured when a request is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (state_q == XF_IDLE && launch_i && line_ok) begin
            row_q <= tgt_row;
        end
    end

    // Outputs
    always_comb begin
        req_o = (state_q == XF_WAIT);
        row_o = row_q;
    end
endmodule

// File: rtl/vid_seq_top.sv
module vid_seq_top
    import vid_seq_pkg::*;
#(
    parameter int H_ACT  = 256,
    parameter int H_FP   = 8,
    parameter int H_SYNC = 24,
    parameter int H_BP   = 32,
    parameter int V_ACT  = 256,
    parameter int V_FP   = 2,
    parameter int V_SYNC = 3,
    parameter int V_BP   = 1,
    localparam int ROW_W = $clog2(V_ACT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_req_i,
    input  logic             xfer_ack_i,
    output logic             sync_o,
    output logic             blank_o,
    output logic             pix_shift_o,
    output logic             adc_en_o,
    output logic             xfer_req_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);

    logic [HW-1:0] hc;
    logic [VW-1:0] vc;
    logic          h_end;
    logic          h_act;
    logic          h_syn;
    logic          v_act;
    logic          v_syn;
    logic          launch;
    logic          vload;
    vmode_e        mode;

    assign h_end  = (hc == HW'(H_TOT - 1));
    assign launch = (hc == HW'(H_ACT));
    assign vload  = (hc == '0) && (vc == VW'(V_ACT));

    raster_cnt #(.TOTAL(H_TOT), .W(HW)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(1'b1),
        .cnt_o (hc)
    );

    raster_cnt #(.TOTAL(V_TOT), .W(VW)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(h_end),
        .cnt_o (vc)
    );

    span_decode #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .W(HW)) u_hdec (
        .cnt_i (hc),
        .act_o (h_act),
        .sync_o(h_syn)
    );

    span_decode #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .W(VW)) u_vdec (
        .cnt_i (vc),
        .act_o (v_act),
        .sync_o(v_syn)
    );

    mode_retime u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (mode_req_i),
        .load_i(vload),
        .mode_o(mode)
    );

    xfer_fsm #(.V_ACT(V_ACT), .V_TOT(V_TOT), .VW(VW), .ROW_W(ROW_W)) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .hblank_i(!h_act),
        .vc_i    (vc),
        .mode_i  (mode),
        .ack_i   (xfer_ack_i),
        .req_o   (xfer_req_o),
        .row_o   (row_o)
    );

    always_comb begin
        pix_shift_o = h_act && v_act;
        blank_o     = !(h_act && v_act);
        sync_o      = h_syn ^ v_syn;
        adc_en_o    = (mode == MODE_DIGITIZE);
    end
endmodule

// File: rtl/vid_seq_chk.sv
module vid_seq_chk #(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_o,
    input logic             blank_o,
    input logic             pix_shift_o,
    input logic             adc_en_o,
    input logic             xfer_req_o,
    input logic             xfer_ack_i,
    input logic [ROW_W-1:0] row_o
);
    assert_no_sync_in_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_shift_o |-> !sync_o);

    assert_mode_in_vblank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_en_o) |-> blank_o);

    // R5 and R6: a request starts only inside blanking
    assert_req_in_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req_o) |-> blank_o);

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_ack_i) |=> xfer_req_o);

    assert_req_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && xfer_ack_i) |=> !xfer_req_o);

    assert_row_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_ack_i) |=> $stable(row_o));
endmodule

bind vid_seq_top vid_seq_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_o     (sync_o),
    .blank_o    (blank_o),
    .pix_shift_o(pix_shift_o),
    .adc_en_o   (adc_en_o),
    .xfer_req_o (xfer_req_o),
    .xfer_ack_i (xfer_ack_i),
    .row_o      (row_o)
);

// File: tb/tb_vid_seq_top.sv
module tb_vid_seq_top;
    localparam int HA = 16, HF = 2, HS = 3, HB = 3;
    localparam int VA = 8,  VF = 1, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int RW = $clog2(VA);
    localparam int NFR = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_req;
    logic          ack;
    logic          sync_w, blank_w, shift_w, adc_w, req_w;
    logic [RW-1:0] row_w;

    int n_chk = 0;
    int n_bad = 0;
    int dly   = 1;
    int seen  = 0;
    int e_mode = 0;
    int req_cnt = 0;
    int win_ok = 0;
    int prev_row = 0;
    int prev_req = 0;

    always #5 clk = ~clk;

    vid_seq_top #(
        .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req_i (mode_req),
        .xfer_ack_i (ack),
        .sync_o     (sync_w),
        .blank_o    (blank_w),
        .pix_shift_o(shift_w),
        .adc_en_o   (adc_w),
        .xfer_req_o (req_w),
        .row_o      (row_w)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int t);
        int hc, vc, line, fr, hs, vs, act, qual, erow, ereq;
        hc   = t % HT;
        line = t / HT;
        vc   = line % VT;
        fr   = line / VT;

        // Effective mode is loaded on the edge at (hc 0, vc VA)
        if (hc == 1 && vc == VA) begin
            e_mode = int'(mode_req);
            chk(int'(adc_w) == e_mode, "R3 mode load at vblank", int'(adc_w), e_mode);
            if (win_ok != 0) chk(req_cnt == VA, "R9 requests per frame", req_cnt, VA);
            win_ok  = 1;
            req_cnt = 0;
        end

        act = (hc < HA && vc < VA) ? 1 : 0;
        chk(int'(shift_w) == act,     "R1 shift enable", int'(shift_w), act);
        chk(int'(blank_w) == 1 - act, "R1 blank",        int'(blank_w), 1 - act);

        hs = (hc >= HA + HF && hc < HA + HF + HS) ? 1 : 0;
        vs = (vc >= VA + VF && vc < VA + VF + VS) ? 1 : 0;
        chk(int'(sync_w) == (hs ^ vs), "R2 composite sync", int'(sync_w), hs ^ vs);

        chk(int'(adc_w) == e_mode, "R4 converter enable", int'(adc_w), e_mode);

        if (e_mode != 0) begin
            qual = (vc < VA) ? 1 : 0;
            erow = vc;
        end else begin
            qual = (vc == VT - 1 || vc < VA - 1) ? 1 : 0;
            erow = (vc == VT - 1) ? 0 : vc + 1;
        end
        ereq = (qual != 0 && hc >= HA + 1 && hc <= HA + dly) ? 1 : 0;
        if (e_mode != 0) chk(int'(req_w) == ereq, "R6/R7 request window", int'(req_w), ereq);
        else             chk(int'(req_w) == ereq, "R5/R7 request window", int'(req_w), ereq);

        if (req_w) begin
            if (e_mode != 0) chk(int'(row_w) == erow, "R6 row index", int'(row_w), erow);
            else             chk(int'(row_w) == erow, "R5 row index", int'(row_w), erow);
            if (prev_req != 0) chk(int'(row_w) == prev_row, "R8 row stable", int'(row_w), prev_row);
            if (prev_req == 0) req_cnt++;
        end
        prev_req = int'(req_w);
        prev_row = int'(row_w);

        // Acknowledge after dly observed request cycles
        if (req_w) begin
            seen++;
            if (seen == dly) ack = 1'b1;
        end else begin
            seen = 0;
            ack  = 1'b0;
        end

        // Stimulus changes for the next cycle
        if (hc == 0 && vc == 0) dly = 1 + (fr % 6);
        if (hc == 0 && vc == 2) begin
            if (fr == 1 || fr == 5) mode_req = 1'b1;
            if (fr == 3 || fr == 8) mode_req = 1'b0;
        end
        // Short glitch in frame 7 must not reach the effective mode (R3)
        if (fr == 7 && vc == 3 && hc == 0) mode_req = ~mode_req;
        if (fr == 7 && vc == 3 && hc == 4) mode_req = ~mode_req;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        mode_req = 1'b0;
        ack      = 1'b0;
        repeat (4) @(negedge clk);
        chk(int'(req_w) == 0, "R7 reset request", int'(req_w), 0);
        chk(int'(adc_w) == 0, "R3 reset mode freeze", int'(adc_w), 0);
        chk(int'(row_w) == 0, "R8 reset row", int'(row_w), 0);
        rst_n = 1'b1;
        for (int t = 0; t < NFR * HT * VT; t++) begin
            if (t > 0) @(negedge clk);
            step(t);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule